// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block keeps a small set of outgoing CAN frames, three by default, and decides which one goes to the protocol engine next. A host loads a frame into a chosen mailbox with one strobe. The strobe writes the identifier, the format and remote flags, the length code and the payload, and it also arms the mailbox. The scheduler then offers the winning frame to the engine with a one-cycle start pulse. It holds that frame steady until the engine reports a result, and then records done, success and arbitration-lost status for that mailbox.

Two mode inputs shape the behaviour. The first picks the ordering. Frames can be ranked the way the bus itself would rank them: base identifier, then the bit after it, then the format bit, then the extension bits, then the extended remote bit, with the smallest value winning. Or frames can be sent in the order they were requested. The second mode picks the failure policy. A failed or lost attempt either stays armed and is tried again, or is dropped after that single try. Serialisation, CRC and bus access belong to the engine and are not part of this block.

Top module: `txmb_sched`

## Requirements
- R1: After reset no mailbox is pending, all done/success/lost flags are 0, and `tx_start` and `tx_active` are low.
- R2: A load strobe sets the addressed mailbox's pending flag on the next edge and clears its done, success and lost flags. While the scheduler is idle, a pending mailbox produces a `tx_start` pulse on the edge after that. During the pulse, `tx_idx` and the frame outputs show that mailbox's contents.
- R3: When `order_by_request` is 0, the pending standard frame with the smallest 11-bit identifier is started first.
- R4: With equal 11-bit base identifiers, a standard frame (`ld_ide`=0) beats an extended one (`ld_ide`=1). A data frame (`ld_rtr`=0) beats a remote frame (`ld_rtr`=1) when everything else is equal. Extended frames with the same base are ranked by the smaller 18-bit extension.
- R5: Frames with identical priority keys are started in ascending mailbox index.
- R6: When `order_by_request` is 1, pending frames are started in the order their loads were accepted, whatever their identifiers.
- R7: When `one_shot` is 0, a result with `eng_ok`=0 leaves the mailbox pending. It sets done=1, success=0 and lost=`eng_alost`, and the frame is started again later.
- R8: When `one_shot` is 1, a mailbox is no longer pending after its first result, whatever that result was.
- R9: A result with `eng_ok`=1 clears pending and sets done=1 and success=1.
- R10: A load aimed at the mailbox whose frame is in flight is ignored. A load aimed at a pending mailbox that is not in flight replaces its frame.
- R11: While `tx_active` is high, the frame outputs do not change and no new start is issued. The choice is made again only after the result arrives.
- R12: `eng_done` is ignored while no attempt is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| order_by_request | input | 1 | 1: request order; 0: identifier priority |
| one_shot | input | 1 | 1: a single attempt per load; 0: retry until success |
| ld_en | input | 1 | Load-and-arm strobe |
| ld_idx | input | IDX_W | Target mailbox |
| ld_base | input | 11 | Base identifier (upper 11 bits of an extended ID) |
| ld_ext | input | 18 | Extension bits (lower 18 bits of an extended ID) |
| ld_ide | input | 1 | 1: extended format |
| ld_rtr | input | 1 | 1: remote frame |
| ld_dlc | input | 4 | Length code |
| ld_data | input | 64 | Payload, byte 0 in bits 63:56 |
| tx_start | output | 1 | One-cycle start pulse to the engine |
| tx_active | output | 1 | An attempt is in flight |
| tx_idx | output | IDX_W | Mailbox of the current attempt |
| tx_base_id | output | 11 | Frame base identifier |
| tx_ext_id | output | 18 | Frame extension bits |
| tx_ide | output | 1 | Frame format flag |
| tx_rtr | output | 1 | Frame remote flag |
| tx_dlc | output | 4 | Frame length code |
| tx_data | output | 64 | Frame payload |
| eng_done | input | 1 | Engine result strobe |
| eng_ok | input | 1 | Result: frame sent successfully |
| eng_alost | input | 1 | Result: arbitration lost |
| mb_pending | output | NUM_MB | Armed flags per mailbox |
| mb_done | output | NUM_MB | Attempt-finished flags |
| mb_ok | output | NUM_MB | Last-attempt success flags |
| mb_alost | output | NUM_MB | Last-attempt arbitration-lost flags |

## Verification
Corrupted priority keys or sequence stamps show up at the very next `tx_start`, as the wrong `tx_idx` or wrong identifier leaving the block. The scoreboard catches this one cycle after the previous result. A bad pending or status update shows in the `mb_*` flags on the edge after `eng_done`, either as a lost retry, an extra attempt or a stale success bit. A wrong in-flight guard appears as frame outputs that change mid-attempt, or as a second start before any result.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
   localparam int BASE_W  = 11;
   localparam int EXT_W   = 18;
   localparam int DLC_W   = 4;
   localparam int BYTES   = 8;
   localparam int DATA_W  = BYTES * 8;
   // base, rtr/srr, ide, ext, ext-rtr
   localparam int KEY_W   = BASE_W + 1 + 1 + EXT_W + 1;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [EXT_W-1:0]  ext;
      logic              ide;
      logic              rtr;
      logic [DLC_W-1:0]  dlc;
      logic [DATA_W-1:0] data;
   } frame_t;

   typedef enum logic {
      SCH_IDLE   = 1'b0,
      SCH_ACTIVE = 1'b1
   } sch_state_t;
endpackage

// File: rtl/txmb_keygen.sv
module txmb_keygen
   import txmb_pkg::*;
#(
   parameter int SEQ_W = 4
) (
   input  logic [BASE_W-1:0] base,
   input  logic [EXT_W-1:0]  ext,
   input  logic              ide,
   input  logic              rtr,
   input  logic [SEQ_W-1:0]  age,
   input  logic              by_request,
   output logic [KEY_W-1:0]  key
);
   localparam int PAD_W = KEY_W - SEQ_W;

   logic [KEY_W-1:0] bus_key;
   logic [KEY_W-1:0] age_key;

   // Extended frames send a recessive bit after the base and a recessive format bit
   always_comb begin
      if (ide) bus_key = {base, 1'b1, 1'b1, ext, rtr};
      else     bus_key = {base, rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
   end

   // Older request => larger age => smaller key
   assign age_key = {{PAD_W{1'b0}}, ~age};
   assign key     = by_request ? age_key : bus_key;
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
   parameter int N     = 3,
   parameter int KEY_W = 32,
   parameter int IDX_W = 2
) (
   input  logic [N*KEY_W-1:0] keys,
   input  logic [N-1:0]       valid,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   logic [KEY_W-1:0] best_key [N];
   logic [IDX_W-1:0] best_idx [N];
   logic             best_vld [N];

   for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign best_key[0] = keys[KEY_W-1:0];
         assign best_idx[0] = '0;
         assign best_vld[0] = valid[0];
      end else begin : g_next
         logic take;
         // strictly smaller: equal keys keep the lower index
         assign take = valid[i] &&
                       (!best_vld[i-1] || (keys[i*KEY_W +: KEY_W] < best_key[i-1]));
         assign best_key[i] = take ? keys[i*KEY_W +: KEY_W] : best_key[i-1];
         assign best_idx[i] = take ? IDX_W'(i) : best_idx[i-1];
         assign best_vld[i] = best_vld[i-1] | valid[i];
      end
   end

   assign any = best_vld[N-1];
   assign idx = best_idx[N-1];
endmodule

// File: rtl/txmb_sched.sv
module txmb_sched
   import txmb_pkg::*;
#(
   parameter int NUM_MB = 3,
   parameter int SEQ_W  = 4,
   localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                order_by_request,
   input  logic                one_shot,
   input  logic                ld_en,
   input  logic [IDX_W-1:0]    ld_idx,
   input  logic [BASE_W-1:0]   ld_base,
   input  logic [EXT_W-1:0]    ld_ext,
   input  logic                ld_ide,
   input  logic                ld_rtr,
   input  logic [DLC_W-1:0]    ld_dlc,
   input  logic [DATA_W-1:0]   ld_data,
   output logic                tx_start,
   output logic                tx_active,
   output logic [IDX_W-1:0]    tx_idx,
   output logic [BASE_W-1:0]   tx_base_id,
   output logic [EXT_W-1:0]    tx_ext_id,
   output logic                tx_ide,
   output logic                tx_rtr,
   output logic [DLC_W-1:0]    tx_dlc,
   output logic [DATA_W-1:0]   tx_data,
   input  logic                eng_done,
   input  logic                eng_ok,
   input  logic                eng_alost,
   output logic [NUM_MB-1:0]   mb_pending,
   output logic [NUM_MB-1:0]   mb_done,
   output logic [NUM_MB-1:0]   mb_ok,
   output logic [NUM_MB-1:0]   mb_alost
);
   if (NUM_MB < 1 || NUM_MB > 16) begin : g_bad_num
      $error("txmb_sched: NUM_MB out of range");
   end
   if ((1 << SEQ_W) <= NUM_MB) begin : g_bad_seq
      $error("txmb_sched: SEQ_W too narrow for NUM_MB");
   end

   frame_t            frame_q [NUM_MB];
   logic [SEQ_W-1:0]  seq_q   [NUM_MB];
   logic [SEQ_W-1:0]  seq_cnt;
   logic [NUM_MB-1:0] pend_q, done_q, ok_q, alost_q;
   sch_state_t        state_q;
   logic [IDX_W-1:0]  cur_q;
   logic              start_q;

   logic [NUM_MB*KEY_W-1:0] keys;
   logic                    pick_any;
   logic [IDX_W-1:0]        pick_idx;
   logic                    ld_ok;
   logic                    fin;

   assign ld_ok = ld_en && (32'(ld_idx) < NUM_MB) &&
                  !(state_q == SCH_ACTIVE && ld_idx == cur_q);
   assign fin   = (state_q == SCH_ACTIVE) && eng_done;

   for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
      logic [SEQ_W-1:0] age;
      assign age = seq_cnt - seq_q[i];

      txmb_keygen #(.SEQ_W(SEQ_W)) keygen_i (
         .base       (frame_q[i].base),
         .ext        (frame_q[i].ext),
         .ide        (frame_q[i].ide),
         .rtr        (frame_q[i].rtr),
         .age        (age),
         .by_request (order_by_request),
         .key        (keys[i*KEY_W +: KEY_W])
      );

      always_ff @(posedge clk) begin
         if (rst) begin
            frame_q[i] <= '0;
            seq_q[i]   <= '0;
            pend_q[i]  <= 1'b0;
            done_q[i]  <= 1'b0;
            ok_q[i]    <= 1'b0;
            alost_q[i] <= 1'b0;
         end else if (ld_ok && ld_idx == IDX_W'(i)) begin
            frame_q[i] <= '{base: ld_base, ext: ld_ext, ide: ld_ide, rtr: ld_rtr,
                            dlc: ld_dlc, data: ld_data};
            seq_q[i]   <= seq_cnt;
            pend_q[i]  <= 1'b1;
            done_q[i]  <= 1'b0;
            ok_q[i]    <= 1'b0;
            alost_q[i] <= 1'b0;
         end else if (fin && cur_q == IDX_W'(i)) begin
            done_q[i]  <= 1'b1;
            ok_q[i]    <= eng_ok;
            alost_q[i] <= eng_alost;
            if (eng_ok || one_shot) pend_q[i] <= 1'b0;
         end
      end
   end

   txmb_pick #(.N(NUM_MB), .KEY_W(KEY_W), .IDX_W(IDX_W)) pick_i (
      .keys  (keys),
      .valid (pend_q),
      .any   (pick_any),
      .idx   (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         seq_cnt <= '0;
         state_q <= SCH_IDLE;
         cur_q   <= '0;
         start_q <= 1'b0;
      end else begin
         if (ld_ok) seq_cnt <= seq_cnt + 1'b1;
         start_q <= 1'b0;
         case (state_q)
            SCH_IDLE: if (pick_any) begin
               state_q <= SCH_ACTIVE;
               cur_q   <= pick_idx;
               start_q <= 1'b1;
            end
            SCH_ACTIVE: if (eng_done) state_q <= SCH_IDLE;
            default: state_q <= SCH_IDLE;
         endcase
      end
   end

   assign tx_start   = start_q;
   assign tx_active  = (state_q == SCH_ACTIVE);
   assign tx_idx     = cur_q;
   assign tx_base_id = frame_q[cur_q].base;
   assign tx_ext_id  = frame_q[cur_q].ext;
   assign tx_ide     = frame_q[cur_q].ide;
   assign tx_rtr     = frame_q[cur_q].rtr;
   assign tx_dlc     = frame_q[cur_q].dlc;
   assign tx_data    = frame_q[cur_q].data;
   assign mb_pending = pend_q;
   assign mb_done    = done_q;
   assign mb_ok      = ok_q;
   assign mb_alost   = alost_q;
endmodule

// File: rtl/txmb_sched_chk.sv
module txmb_sched_chk #(
   parameter int NUM_MB = 3,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              one_shot,
   input logic              ld_en,
   input logic              tx_start,
   input logic              tx_active,
   input logic [IDX_W-1:0]  tx_idx,
   input logic [10:0]       tx_base_id,
   input logic [17:0]       tx_ext_id,
   input logic [3:0]        tx_dlc,
   input logic              eng_done,
   input logic              eng_ok,
   input logic [NUM_MB-1:0] mb_pending,
   input logic [NUM_MB-1:0] mb_done
);
   // R2
   start_pending_chk: assert property (@(posedge clk) disable iff (rst)
      tx_start |-> mb_pending[tx_idx]);

   // R11
   start_gap_chk: assert property (@(posedge clk) disable iff (rst)
      tx_start |=> !tx_start);

   // R11
   frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_active && $past(tx_active) && !$past(rst))
      |-> ($stable(tx_base_id) && $stable(tx_ext_id) && $stable(tx_dlc) && $stable(tx_idx)));

   // R9
   success_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_active && eng_done && eng_ok)
      |=> (!mb_pending[$past(tx_idx)] && mb_done[$past(tx_idx)]));

   // R8
   single_try_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_active && eng_done && one_shot) |=> !mb_pending[$past(tx_idx)]);

   // R7
   retry_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_active && eng_done && !eng_ok && !one_shot) |=> mb_pending[$past(tx_idx)]);

   // R12
   idle_result_chk: assert property (@(posedge clk) disable iff (rst)
      (!tx_active && eng_done && !ld_en) |=> $stable(mb_done));
endmodule

bind txmb_sched txmb_sched_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst(rst), .one_shot(one_shot), .ld_en(ld_en),
   .tx_start(tx_start), .tx_active(tx_active), .tx_idx(tx_idx),
   .tx_base_id(tx_base_id), .tx_ext_id(tx_ext_id), .tx_dlc(tx_dlc),
   .eng_done(eng_done), .eng_ok(eng_ok),
   .mb_pending(mb_pending), .mb_done(mb_done)
);

// File: tb/txmb_sched_tb_top.sv
module txmb_sched_tb_top;
   localparam int ENG_LAT = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        order_by_request = 1'b0;
   logic        one_shot = 1'b0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_idx = '0;
   logic [10:0] ld_base = '0;
   logic [17:0] ld_ext = '0;
   logic        ld_ide = 1'b0;
   logic        ld_rtr = 1'b0;
   logic [3:0]  ld_dlc = '0;
   logic [63:0] ld_data = '0;
   logic        tx_start, tx_active;
   logic [1:0]  tx_idx;
   logic [10:0] tx_base_id;
   logic [17:0] tx_ext_id;
   logic        tx_ide, tx_rtr;
   logic [3:0]  tx_dlc;
   logic [63:0] tx_data;
   logic        eng_done = 1'b0;
   logic        eng_ok = 1'b0;
   logic        eng_alost = 1'b0;
   logic [2:0]  mb_pending, mb_done, mb_ok, mb_alost;

   always #5 clk = ~clk;

   txmb_sched dut_i (
      .clk(clk), .rst(rst), .order_by_request(order_by_request), .one_shot(one_shot),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_ext(ld_ext),
      .ld_ide(ld_ide), .ld_rtr(ld_rtr), .ld_dlc(ld_dlc), .ld_data(ld_data),
      .tx_start(tx_start), .tx_active(tx_active), .tx_idx(tx_idx),
      .tx_base_id(tx_base_id), .tx_ext_id(tx_ext_id), .tx_ide(tx_ide),
      .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data),
      .eng_done(eng_done), .eng_ok(eng_ok), .eng_alost(eng_alost),
      .mb_pending(mb_pending), .mb_done(mb_done), .mb_ok(mb_ok), .mb_alost(mb_alost)
   );

   typedef struct {
      int idx;
      int base;
      int ext;
      int ide;
   } exp_t;

   exp_t  exp_q[$];
   bit    res_q[$];
   string cur_req = "R2";
   int    n_cmp = 0;
   int    n_bad = 0;

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Driver: called at a falling edge, returns one falling edge later
   task automatic load(int idx, int base, int ext, bit ide, bit rtr);
      ld_en   = 1'b1;
      ld_idx  = 2'(idx);
      ld_base = 11'(base);
      ld_ext  = 18'(ext);
      ld_ide  = ide;
      ld_rtr  = rtr;
      ld_dlc  = 4'(idx + 1);
      ld_data = {8{8'(base)}};
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   task automatic expect_tx(int idx, int base, int ext, int ide);
      exp_t e;
      e.idx = idx; e.base = base; e.ext = ext; e.ide = ide;
      exp_q.push_back(e);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (exp_q.size() != 0 || tx_active || mb_pending != 3'b000) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // Monitor and engine model
   initial begin
      forever begin
         @(negedge clk);
         if (tx_start && !rst) begin
            automatic int idx = int'(tx_idx);
            automatic bit ok = 1'b1;
            if (exp_q.size() == 0) begin
               chk({cur_req, " unexpected start idx"}, idx, 99);
            end else begin
               automatic exp_t e = exp_q.pop_front();
               chk({cur_req, " start idx"}, idx, e.idx);
               chk({cur_req, " start base"}, int'(tx_base_id), e.base);
               chk({cur_req, " start ext"}, int'(tx_ext_id), e.ext);
               chk({cur_req, " start ide"}, int'(tx_ide), e.ide);
            end
            if (res_q.size() != 0) ok = res_q.pop_front();
            repeat (ENG_LAT) @(negedge clk);
            chk("R11 frame held", int'(tx_idx), idx);
            eng_done  = 1'b1;
            eng_ok    = ok;
            eng_alost = !ok;
            @(negedge clk);
            eng_done  = 1'b0;
            chk(ok ? "R9 done" : (one_shot ? "R8 done" : "R7 done"), int'(mb_done[idx]), 1);
            chk(ok ? "R9 ok" : "R7 ok", int'(mb_ok[idx]), int'(ok));
            chk(ok ? "R9 alost" : "R7 alost", int'(mb_alost[idx]), int'(!ok));
            chk(ok ? "R9 pending" : (one_shot ? "R8 pending" : "R7 pending"),
                int'(mb_pending[idx]), int'(!ok && !one_shot));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 pending", int'(mb_pending), 0);
      chk("R1 done", int'(mb_done), 0);
      chk("R1 ok", int'(mb_ok), 0);
      chk("R1 start", int'(tx_start), 0);
      chk("R1 active", int'(tx_active), 0);

      // R2 / R3 / R10: identifier order, ignored load into in-flight mailbox
      cur_req = "R3";
      expect_tx(0, 'h300, 0, 0);
      expect_tx(2, 'h050, 0, 0);
      expect_tx(1, 'h100, 0, 0);
      load(0, 'h300, 0, 0, 0);
      chk("R2 pending after load", int'(mb_pending[0]), 1);
      load(1, 'h100, 0, 0, 0);
      load(2, 'h050, 0, 0, 0);
      load(0, 'h001, 0, 0, 0);   // R10 in flight: ignored
      wait_idle();
      chk("R9 all done", int'(mb_done), 7);
      chk("R10 no extra pending", int'(mb_pending), 0);

      // R4: standard remote beats extended with same base
      cur_req = "R4";
      expect_tx(0, 'h7FF, 0, 0);
      expect_tx(2, 'h123, 0, 0);
      expect_tx(1, 'h123, 5, 1);
      load(0, 'h7FF, 0, 0, 0);
      load(1, 'h123, 5, 1, 0);
      load(2, 'h123, 0, 0, 1);
      wait_idle();
      // R4: data beats remote
      expect_tx(0, 'h7FF, 0, 0);
      expect_tx(2, 'h010, 0, 0);
      expect_tx(1, 'h010, 0, 0);
      load(0, 'h7FF, 0, 0, 0);
      load(1, 'h010, 0, 0, 1);
      load(2, 'h010, 0, 0, 0);
      wait_idle();
      // R4: extension bits rank extended frames
      expect_tx(0, 'h7FF, 0, 0);
      expect_tx(2, 'h005, 3, 1);
      expect_tx(1, 'h005, 9, 1);
      load(0, 'h7FF, 0, 0, 0);
      load(1, 'h005, 9, 1, 0);
      load(2, 'h005, 3, 1, 0);
      wait_idle();

      // R5: identical keys by index
      cur_req = "R5";
      expect_tx(0, 'h7FF, 0, 0);
      expect_tx(1, 'h0AA, 0, 0);
      expect_tx(2, 'h0AA, 0, 0);
      load(0, 'h7FF, 0, 0, 0);
      load(2, 'h0AA, 0, 0, 0);
      load(1, 'h0AA, 0, 0, 0);
      wait_idle();

      // R10: replacing a pending, not in-flight frame
      cur_req = "R10";
      expect_tx(0, 'h7F0, 0, 0);
      expect_tx(1, 'h020, 0, 0);
      expect_tx(2, 'h100, 0, 0);
      load(0, 'h7F0, 0, 0, 0);
      load(1, 'h400, 0, 0, 0);
      load(1, 'h020, 0, 0, 0);
      load(2, 'h100, 0, 0, 0);
      wait_idle();

      // R6: request order
      cur_req = "R6";
      order_by_request = 1'b1;
      expect_tx(0, 'h7FF, 0, 0);
      expect_tx(2, 'h400, 0, 0);
      expect_tx(1, 'h010, 0, 0);
      load(0, 'h7FF, 0, 0, 0);
      load(2, 'h400, 0, 0, 0);
      load(1, 'h010, 0, 0, 0);
      wait_idle();
      order_by_request = 1'b0;

      // R7: retry after failure
      cur_req = "R7";
      res_q.push_back(1'b0);
      res_q.push_back(1'b1);
      expect_tx(1, 'h0F0, 0, 0);
      expect_tx(1, 'h0F0, 0, 0);
      load(1, 'h0F0, 0, 0, 0);
      wait_idle();
      chk("R7 final ok", int'(mb_ok[1]), 1);

      // R8: one-shot
      cur_req = "R8";
      one_shot = 1'b1;
      res_q.push_back(1'b0);
      expect_tx(2, 'h0E0, 0, 0);
      load(2, 'h0E0, 0, 0, 0);
      wait_idle();
      chk("R8 not retried", int'(mb_pending[2]), 0);
      chk("R8 ok stays 0", int'(mb_ok[2]), 0);

      // R12: result strobe while idle
      cur_req = "R12";
      eng_done = 1'b1;
      eng_ok   = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      @(negedge clk);
      chk("R12 ok unchanged", int'(mb_ok[2]), 0);
      chk("R12 done unchanged", int'(mb_done[2]), 1);
      chk("R12 active", int'(tx_active), 0);
      one_shot = 1'b0;
      repeat (5) @(negedge clk);
      chk("R11 queue drained", exp_q.size(), 0);
      finish_run();
   end
endmodule